// File: doc/BRIEF.md
# Skewed Two-Lane Pipelined Ripple Adder

This block adds two 4-bit unsigned (or two's complement) numbers using a ripple-carry chain cut in the middle by one register. The low lane adds operand bits [1:0]. The high lane adds bits [3:2]. The only state between the lanes is the carry out of the low lane, captured at the clock edge. A caller can start a new addition every cycle. Each adder lane then sees only half of the carry chain per clock period, while the time to the final sum bit stays about the same as in an unbroken ripple adder.

The data is skewed in time. In cycle t the caller presents the low operand bits with `in_valid`, and `s_lo` for that operation appears combinationally in the same cycle. In cycle t+1 the caller presents the high operand bits of the same operation. `s_hi` and `cout` then appear in that cycle, together with `out_valid`. A consumer must align `s_lo` from cycle t with `s_hi` from cycle t+1.

Top module: `skew_ripple_add`

## Requirements
- R1: In every cycle `s_lo` equals bits [1:0] of `a_lo + b_lo`, with no carry into the low lane. This holds in the same cycle the operands are presented.
- R2: In a cycle where `out_valid` is 1, `{cout, s_hi}` equals `a_hi + b_hi + k`. Here `k` is the carry out of the low lane (bit 2 of `a_lo + b_lo`) in the previous cycle, and `cout` is the most significant bit.
- R3: `out_valid` equals the `in_valid` sampled at the previous rising clock edge.
- R4: A synchronous active-high `rst` clears the stored carry and `out_valid`. In the cycle after a reset edge, `out_valid` is 0 and `{cout, s_hi}` equals `a_hi + b_hi`, even if a valid operation with a low-lane carry was offered at the reset edge.
- R5: A cycle with `in_valid` at 0 passes no carry to the next cycle. The next cycle's `{cout, s_hi}` equals `a_hi + b_hi`.
- R6: A new operation can enter in every cycle with no bubbles. Each operation in a back-to-back stream gets its own correct high result.
- R7: For any operation, the 5-bit value `{cout, s_hi, s_lo}` equals `A + B`. Here `s_hi` is taken one cycle after `s_lo`, and `A = {a_hi, a_lo}`, `B = {b_hi, b_lo}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Low operand bits of a new operation are present this cycle |
| a_lo | input | LANE_W | Operand A bits [1:0], operation issued this cycle |
| b_lo | input | LANE_W | Operand B bits [1:0], operation issued this cycle |
| a_hi | input | LANE_W | Operand A bits [3:2], operation issued last cycle |
| b_hi | input | LANE_W | Operand B bits [3:2], operation issued last cycle |
| s_lo | output | LANE_W | Sum bits [1:0] of the operation issued this cycle |
| s_hi | output | LANE_W | Sum bits [3:2] of the operation issued last cycle |
| cout | output | 1 | Carry out of bit 3 of the operation issued last cycle |
| out_valid | output | 1 | `s_hi` and `cout` belong to a valid operation |

## Verification
The bench builds the block with the default `LANE_W` of 2, which gives a 4-bit adder. At that width every one of the 256 operand pairs can be driven in one back-to-back stream, so each low-lane carry case and each high-lane carry-in case is reached. Further streams insert bubbles and reset edges between operations that produce a carry, which exercises how the stored carry is cleared.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
  // State held between the two lanes
  typedef struct packed {
    logic carry;
    logic valid;
  } seam_t;

  localparam seam_t SEAM_IDLE = '{carry: 1'b0, valid: 1'b0};
endpackage

// File: rtl/sra_fa_cell.sv
`timescale 1ns/1ps
module sra_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = a ^ b;
  assign s    = half ^ ci;
  assign co   = (a & b) | (half & ci);
endmodule

// File: rtl/sra_lane.sv
`timescale 1ns/1ps
module sra_lane #(
  parameter int LW = 2
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          cin,
  output logic [LW-1:0] s,
  output logic          cout
);
  logic [LW:0] chain;
  assign chain[0] = cin;

  generate
    for (genvar i = 0; i < LW; i++) begin : g_bit
      sra_fa_cell u_fa (
        .a (a[i]),
        .b (b[i]),
        .ci(chain[i]),
        .s (s[i]),
        .co(chain[i+1])
      );
    end
  endgenerate

  assign cout = chain[LW];
endmodule

// File: rtl/sra_seam.sv
`timescale 1ns/1ps
module sra_seam (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic carry_in,
  output logic carry_q,
  output logic valid_q
);
  import sra_pkg::*;

  seam_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SEAM_IDLE;
    end else begin
      st.valid <= in_valid;
      st.carry <= in_valid & carry_in;
    end
  end

  assign carry_q = st.carry;
  assign valid_q = st.valid;

  // R5: an idle cycle leaves no carry behind
  a_r5_idle_drops_carry: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !carry_q);
endmodule

// File: rtl/skew_ripple_add.sv
`timescale 1ns/1ps
module skew_ripple_add #(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LANE_W-1:0] a_lo,
  input  logic [LANE_W-1:0] b_lo,
  input  logic [LANE_W-1:0] a_hi,
  input  logic [LANE_W-1:0] b_hi,
  output logic [LANE_W-1:0] s_lo,
  output logic [LANE_W-1:0] s_hi,
  output logic              cout,
  output logic              out_valid
);
  localparam int EXT_W = LANE_W + 1;

  logic lo_carry;
  logic seam_carry;

  sra_lane #(.LW(LANE_W)) u_lo (
    .a   (a_lo),
    .b   (b_lo),
    .cin (1'b0),
    .s   (s_lo),
    .cout(lo_carry)
  );

  sra_seam u_seam (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .carry_in(lo_carry),
    .carry_q (seam_carry),
    .valid_q (out_valid)
  );

  sra_lane #(.LW(LANE_W)) u_hi (
    .a   (a_hi),
    .b   (b_hi),
    .cin (seam_carry),
    .s   (s_hi),
    .cout(cout)
  );

  // Arithmetic references for the checks below, independent of the cells
  logic [EXT_W-1:0] lo_ref;
  logic [EXT_W-1:0] hi_plain;
  assign lo_ref   = {1'b0, a_lo} + {1'b0, b_lo};
  assign hi_plain = {1'b0, a_hi} + {1'b0, b_hi};

  // R1
  a_r1_lo_sum: assert property (@(posedge clk) disable iff (rst)
    s_lo == lo_ref[LANE_W-1:0]);

  // R2
  a_r2_hi_sum: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({cout, s_hi} == hi_plain + EXT_W'($past(lo_ref[LANE_W]))));

  // R3
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r3_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4
  a_r4_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && ({cout, s_hi} == hi_plain)));
endmodule

// File: tb/skew_ripple_add_bench.sv
`timescale 1ns/1ps
module skew_ripple_add_bench;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [LW-1:0] a_lo = '0, b_lo = '0, a_hi = '0, b_hi = '0;
  logic [LW-1:0] s_lo, s_hi;
  logic          cout, out_valid;

  always #2.5 clk = ~clk;

  skew_ripple_add #(.LANE_W(LW)) u_skew_ripple_add (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_lo(a_lo), .b_lo(b_lo), .a_hi(a_hi), .b_hi(b_hi),
    .s_lo(s_lo), .s_hi(s_hi), .cout(cout), .out_valid(out_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state: the previously issued operation
  logic [3:0] p_a = '0, p_b = '0;
  logic [1:0] p_lo = '0;
  bit p_v = 0, p_r = 1;
  string hi_tag = "R2";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] a, input logic [3:0] b, input bit r);
    logic [4:0] full;
    logic [2:0] plain;
    @(negedge clk);
    rst = r; in_valid = v;
    a_lo = a[1:0]; b_lo = b[1:0];
    a_hi = p_a[3:2]; b_hi = p_b[3:2];
    #1;
    full = {1'b0, a} + {1'b0, b};
    chk("R1", int'(s_lo), int'(full[1:0]));
    chk("R3", int'(out_valid), int'(p_v));
    if (p_v) begin
      full = {1'b0, p_a} + {1'b0, p_b};
      chk(hi_tag, int'({cout, s_hi}), int'(full[4:2]));
      chk("R7", int'({cout, s_hi, p_lo}), int'(full));
    end else begin
      plain = {1'b0, p_a[3:2]} + {1'b0, p_b[3:2]};
      chk(p_r ? "R4" : "R5", int'({cout, s_hi}), int'(plain));
    end
    p_a = a; p_b = b; p_lo = s_lo;
    p_v = v && !r; p_r = r;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset held while valid operations with carries are offered
    rst = 1'b1; in_valid = 1'b1; a_lo = 2'd3; b_lo = 2'd3; a_hi = 2'd3; b_hi = 2'd2;
    repeat (3) @(negedge clk);
    #1;
    chk("R4", int'(out_valid), 0);
    chk("R4", int'({cout, s_hi}), 5);
    p_a = 4'hF; p_b = 4'hB; p_v = 0; p_r = 1;

    // R6: every pair, back to back, no bubbles
    hi_tag = "R6";
    for (int i = 0; i < 256; i++) step(1'b1, i[7:4], i[3:0], 1'b0);
    hi_tag = "R2";

    // R5: bubbles after operations that carry out of the low lane
    for (int i = 0; i < 24; i++)
      step(i[0] == 1'b0, 4'(i * 7 + 3), 4'(i * 5 + 1), 1'b0);
    step(1'b1, 4'h3, 4'h1, 1'b0);
    step(1'b0, 4'hA, 4'h6, 1'b0);
    step(1'b1, 4'h7, 4'h9, 1'b0);

    // R4: reset edge right after a carrying operation, then resume
    step(1'b1, 4'hB, 4'h7, 1'b0);
    step(1'b1, 4'hF, 4'hF, 1'b1);
    step(1'b1, 4'hE, 4'h3, 1'b0);
    step(1'b1, 4'h2, 4'h2, 1'b0);
    step(1'b0, 4'h0, 4'h0, 1'b0);
    step(1'b0, 4'h0, 4'h0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule